// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps a small table of saved radio calibration words for each receive chain. Each table has six entries of 28 bits. Entries 0, 1 and 2 hold the loop, low and high DC-offset DAC settings. Entry 3 holds the filter cutoff trim, entry 4 the receive gain setting and entry 5 the peak-detector offset. Software reaches the tables through a small register file. Each chain has a command register and a data register. A table read or write starts when software sets the go bit in the command register, and that bit falls by itself when the access is complete.

A global control register has four fields: an enable, a per-entry replay mask, a per-chain replay enable and a force-replay bit. When software sets force-replay, a sequencer walks the selected chain and entry pairs and puts one saved word per clock on an output bus. The bus carries a valid strobe, the chain number, the entry index and the data. When the last word has been sent, the force bit clears.

The register file decodes seven word addresses. Address 0 is the control register. Address 1+2c is the command register of chain c, and address 2+2c is its data register. Read data comes out one clock after the address is presented.

Top module: `calib_retain_ctrl`

## Requirements
- R1: After reset, every register reads zero, no busy flag or replay output is active, and every table entry reads back as zero.
- R2: The control register keeps these fields and reads them back:
  - enable at bit 0
  - force-replay at bit 1
  - replay mask at bits 13:8, where bit 8+i selects entry i
  - chain enable at bits 18:16, where bit 16+c selects chain c
- R3: A command write carries the entry number in bits 2:0, the write flag in bit 4 and go in bit 8. When it has go=1 and write=1, the current data register value is stored into that entry of that chain.
- R4: When go=1 and write=0, the selected entry is copied into the chain's data register. Software can read it there once go has cleared.
- R5: An accepted access keeps its chain's busy flag, and the go bit seen in the command register, high for exactly two clocks after the accepting edge.
- R6: An entry number of 6 or 7 still completes in two clocks. A write to it changes nothing, and a read of it returns zero.
- R7: While enable is 0, a go request is dropped: no busy flag and no table change. A force request written together with enable=0 is also dropped.
- R8: A replay sends every pair that has its chain enabled and its entry masked. Pairs go out in ascending chain order, and by ascending entry within a chain. They appear on consecutive clocks, starting three clocks after the control write, and each carries its chain, index and stored word.
- R9: The force bit stays set against software writes of 0. It clears on the same clock as the last replay word. If nothing is selected, it clears one clock after it was set and no word is sent.
- R10: A go request made while a replay is pending or running is dropped, with no busy flag and no table change. A data or command register write to a chain that is busy is also dropped.
- R11: The chains have separate tables: the same entry number on different chains holds independent values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after the address |
| acc_busy_o | output | 3 | Per-chain table access in progress |
| restore_busy_o | output | 1 | Force-replay pending or running |
| replay_valid_o | output | 1 | Replay word valid |
| replay_chain_o | output | 2 | Chain of the replay word |
| replay_index_o | output | 3 | Entry index of the replay word |
| replay_data_o | output | 28 | Stored calibration word being replayed |

## Verification
The assertions assume that software changes a register only through single-cycle write strobes. They also assume that table accesses and replays are never in flight together, because the acceptance gating keeps them apart. The bench drives one register operation at a time and waits for each access to finish by counting clocks. It deliberately issues go and data writes into busy windows and during replays, and writes force-replay with enable both set and cleared. Random traffic mixes reads, writes and out-of-range entries across all chains. Directed replays cover empty, single-chain and full masks.

// File: rtl/calib_retain_pkg.sv
`timescale 1ns/1ps
package calib_retain_pkg;
  localparam int REG_W          = 32;
  // control register fields
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FORCE_BIT = 1;
  localparam int CTRL_MASK_LSB  = 8;
  localparam int CTRL_CHAIN_LSB = 16;
  // per-chain command register fields
  localparam int CMD_IDX_LSB    = 0;
  localparam int CMD_WR_BIT     = 4;
  localparam int CMD_GO_BIT     = 8;

  typedef enum logic [1:0] {RP_IDLE, RP_RUN, RP_TAIL} rp_state_e;
endpackage

// File: rtl/calib_retain_bank.sv
`timescale 1ns/1ps
module calib_retain_bank
  import calib_retain_pkg::*;
#(
  parameter int NENTRY = 6,
  parameter int DW     = 28,
  localparam int EW    = (NENTRY > 1) ? $clog2(NENTRY) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [EW-1:0]     cmd_idx,
  input  logic              cmd_wr,
  input  logic              cmd_go,
  input  logic              data_we,
  input  logic [DW-1:0]     wr_data,
  input  logic              acc_allow,
  input  logic              rp_rd_en,
  input  logic [EW-1:0]     rp_idx,
  output logic [REG_W-1:0]  cmd_view,
  output logic [DW-1:0]     data_view,
  output logic              busy,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0]     mem [NENTRY];
  logic [NENTRY-1:0] written_q;
  logic [EW-1:0]     idx_q;
  logic              wr_q, busy_q, phase_q, hit_q;
  logic [DW-1:0]     data_q, rd_q;
  logic              start, ram_we, ra_ok, wa_ok;
  logic [EW-1:0]     ra, ra_safe;

  assign start   = cmd_we && cmd_go && acc_allow && !busy_q;
  assign ra      = rp_rd_en ? rp_idx : idx_q;
  assign ra_ok   = ({1'b0, ra} < (EW+1)'(NENTRY));
  assign wa_ok   = ({1'b0, idx_q} < (EW+1)'(NENTRY));
  assign ra_safe = ra_ok ? ra : '0;
  assign ram_we  = busy_q && !phase_q && wr_q && wa_ok;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (ram_we) mem[idx_q] <= data_q;
    rd_q <= mem[ra_safe];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      idx_q     <= '0;
      wr_q      <= 1'b0;
      busy_q    <= 1'b0;
      phase_q   <= 1'b0;
      data_q    <= '0;
      hit_q     <= 1'b0;
    end else begin
      hit_q <= ra_ok && written_q[ra_safe];
      if (ram_we) written_q[idx_q] <= 1'b1;
      if (cmd_we && !busy_q) begin
        idx_q <= cmd_idx;
        wr_q  <= cmd_wr;
      end
      if (start) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
      end else if (busy_q && !phase_q) begin
        phase_q <= 1'b1;
      end else if (busy_q) begin
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
        if (!wr_q) data_q <= rd_data;
      end
      if (data_we && !busy_q) data_q <= wr_data;
    end
  end

  assign rd_data   = hit_q ? rd_q : '0;
  assign busy      = busy_q;
  assign data_view = data_q;

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_IDX_LSB +: EW] = idx_q;
    cmd_view[CMD_WR_BIT]        = wr_q;
    cmd_view[CMD_GO_BIT]        = busy_q;
  end

  // R5
  acc_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy ##1 busy ##1 !busy);

  // R7
  acc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(acc_allow && cmd_we));
endmodule

// File: rtl/calib_retain_replay.sv
`timescale 1ns/1ps
module calib_retain_replay
  import calib_retain_pkg::*;
#(
  parameter int NCHAIN = 3,
  parameter int NENTRY = 6,
  parameter int DW     = 28,
  localparam int EW    = (NENTRY > 1) ? $clog2(NENTRY) : 1,
  localparam int CW    = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
  localparam int NSLOT = NCHAIN * NENTRY
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go,
  input  logic [NSLOT-1:0]           sel,
  input  logic [NCHAIN-1:0][DW-1:0]  bank_rd,
  output logic [NCHAIN-1:0]          rd_en,
  output logic [EW-1:0]              rd_idx,
  output logic                       done,
  output logic                       busy,
  output logic                       out_valid,
  output logic [CW-1:0]              out_chain,
  output logic [EW-1:0]              out_idx,
  output logic [DW-1:0]              out_data
);
  rp_state_e        st;
  logic [NSLOT-1:0] sel_q, srch_sel;
  logic [CW-1:0]    cur_c, srch_c, base_c, p_c;
  logic [EW-1:0]    cur_e, srch_e, base_e, p_e;
  logic             incl, srch_found, p_valid;

  assign srch_sel = (st == RP_IDLE) ? sel : sel_q;
  assign base_c   = (st == RP_IDLE) ? '0 : cur_c;
  assign base_e   = (st == RP_IDLE) ? '0 : cur_e;
  assign incl     = (st == RP_IDLE);

  // smallest selected slot after (or at, when idle) the base position
  always_comb begin
    srch_found = 1'b0;
    srch_c     = '0;
    srch_e     = '0;
    for (int c = NCHAIN - 1; c >= 0; c--) begin
      for (int e = NENTRY - 1; e >= 0; e--) begin
        if (srch_sel[c*NENTRY + e] &&
            ((c > int'(base_c)) ||
             (c == int'(base_c) && ((e > int'(base_e)) || (incl && e == int'(base_e)))))) begin
          srch_found = 1'b1;
          srch_c     = CW'(c);
          srch_e     = EW'(e);
        end
      end
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_rden
    assign rd_en[c] = (st == RP_RUN) && (cur_c == CW'(c));
  end
  assign rd_idx = cur_e;
  assign done   = ((st == RP_IDLE) && go && !srch_found) || (st == RP_TAIL);
  assign busy   = (st != RP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RP_IDLE;
      sel_q     <= '0;
      cur_c     <= '0;
      cur_e     <= '0;
      p_valid   <= 1'b0;
      p_c       <= '0;
      p_e       <= '0;
      out_valid <= 1'b0;
      out_chain <= '0;
      out_idx   <= '0;
      out_data  <= '0;
    end else begin
      p_valid <= (st == RP_RUN);
      if (st == RP_RUN) begin
        p_c <= cur_c;
        p_e <= cur_e;
      end
      out_valid <= p_valid;
      if (p_valid) begin
        out_chain <= p_c;
        out_idx   <= p_e;
        out_data  <= bank_rd[p_c];
      end
      case (st)
        RP_IDLE: if (go && srch_found) begin
          sel_q <= sel;
          cur_c <= srch_c;
          cur_e <= srch_e;
          st    <= RP_RUN;
        end
        RP_RUN: if (srch_found) begin
          cur_c <= srch_c;
          cur_e <= srch_e;
        end else begin
          st <= RP_TAIL;
        end
        RP_TAIL: st <= RP_IDLE;
        default: st <= RP_IDLE;
      endcase
    end
  end

  // R8
  replay_index_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_idx} < (EW+1)'(NENTRY)));

  // R8
  replay_chain_chk: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> $past(busy));
endmodule

// File: rtl/calib_retain_ctrl.sv
`timescale 1ns/1ps
module calib_retain_ctrl
  import calib_retain_pkg::*;
#(
  parameter int NCHAIN = 3,
  parameter int NENTRY = 6,
  parameter int DW     = 28,
  localparam int EW    = (NENTRY > 1) ? $clog2(NENTRY) : 1,
  localparam int CW    = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
  localparam int AW    = $clog2(2*NCHAIN + 1),
  localparam int NSLOT = NCHAIN * NENTRY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCHAIN-1:0] acc_busy_o,
  output logic              restore_busy_o,
  output logic              replay_valid_o,
  output logic [CW-1:0]     replay_chain_o,
  output logic [EW-1:0]     replay_index_o,
  output logic [DW-1:0]     replay_data_o
);
  logic              en_q, force_q;
  logic [NENTRY-1:0] mask_q;
  logic [NCHAIN-1:0] chains_q;
  logic              ctrl_we, acc_allow, rp_go, rp_done, rp_busy;
  logic [NSLOT-1:0]  sel;
  logic [NCHAIN-1:0] bank_busy, rp_rd_en;
  logic [EW-1:0]     rp_idx;
  logic [NCHAIN-1:0][DW-1:0]    bank_rd;
  logic [NCHAIN-1:0][REG_W-1:0] cmd_view;
  logic [NCHAIN-1:0][DW-1:0]    data_view;
  logic [REG_W-1:0]  ctrl_view, rd_mux;

  if (DW < REG_W) begin : g_unused
    logic unused_wbits;
    assign unused_wbits = ^reg_wdata[REG_W-1:DW];
  end

  assign ctrl_we   = reg_we && (reg_addr == '0);
  assign acc_allow = en_q && !force_q;
  assign rp_go     = force_q && !(|bank_busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      force_q  <= 1'b0;
      mask_q   <= '0;
      chains_q <= '0;
    end else begin
      if (ctrl_we) begin
        en_q     <= reg_wdata[CTRL_EN_BIT];
        mask_q   <= reg_wdata[CTRL_MASK_LSB +: NENTRY];
        chains_q <= reg_wdata[CTRL_CHAIN_LSB +: NCHAIN];
      end
      if (rp_done)
        force_q <= 1'b0;
      else if (ctrl_we && reg_wdata[CTRL_EN_BIT] && reg_wdata[CTRL_FORCE_BIT])
        force_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    for (genvar e = 0; e < NENTRY; e++) begin : g_sel
      assign sel[c*NENTRY + e] = chains_q[c] & mask_q[e];
    end

    calib_retain_bank #(.NENTRY(NENTRY), .DW(DW)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .cmd_we    (reg_we && (reg_addr == AW'(1 + 2*c))),
      .cmd_idx   (reg_wdata[CMD_IDX_LSB +: EW]),
      .cmd_wr    (reg_wdata[CMD_WR_BIT]),
      .cmd_go    (reg_wdata[CMD_GO_BIT]),
      .data_we   (reg_we && (reg_addr == AW'(2 + 2*c))),
      .wr_data   (reg_wdata[DW-1:0]),
      .acc_allow (acc_allow),
      .rp_rd_en  (rp_rd_en[c]),
      .rp_idx    (rp_idx),
      .cmd_view  (cmd_view[c]),
      .data_view (data_view[c]),
      .busy      (bank_busy[c]),
      .rd_data   (bank_rd[c])
    );
  end

  calib_retain_replay #(.NCHAIN(NCHAIN), .NENTRY(NENTRY), .DW(DW)) u_replay (
    .clk       (clk),
    .rst       (rst),
    .go        (rp_go),
    .sel       (sel),
    .bank_rd   (bank_rd),
    .rd_en     (rp_rd_en),
    .rd_idx    (rp_idx),
    .done      (rp_done),
    .busy      (rp_busy),
    .out_valid (replay_valid_o),
    .out_chain (replay_chain_o),
    .out_idx   (replay_index_o),
    .out_data  (replay_data_o)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN_BIT]                  = en_q;
    ctrl_view[CTRL_FORCE_BIT]               = force_q;
    ctrl_view[CTRL_MASK_LSB +: NENTRY]      = mask_q;
    ctrl_view[CTRL_CHAIN_LSB +: NCHAIN]     = chains_q;
    rd_mux = '0;
    if (reg_addr == '0) rd_mux = ctrl_view;
    for (int c = 0; c < NCHAIN; c++) begin
      if (reg_addr == AW'(1 + 2*c)) rd_mux = cmd_view[c];
      if (reg_addr == AW'(2 + 2*c)) rd_mux = REG_W'(data_view[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign acc_busy_o     = bank_busy;
  assign restore_busy_o = force_q;

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rp_busy && (|bank_busy)));

  // R9
  force_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(force_q) |-> $past(rp_done));

  // R8
  valid_in_restore_chk: assert property (@(posedge clk) disable iff (rst)
    replay_valid_o |-> $past(force_q));

  // R7
  force_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(force_q) |-> $past(ctrl_we && reg_wdata[CTRL_EN_BIT]));
endmodule

// File: tb/tb_calib_retain_ctrl.sv
`timescale 1ns/1ps
module tb_calib_retain_ctrl;
  localparam int NCH = 3;
  localparam int NEN = 6;
  localparam int DW  = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  acc_busy_o;
  logic        restore_busy_o, replay_valid_o;
  logic [1:0]  replay_chain_o;
  logic [2:0]  replay_index_o;
  logic [27:0] replay_data_o;

  always #2.5 clk = ~clk;

  calib_retain_ctrl dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_busy_o(acc_busy_o),
    .restore_busy_o(restore_busy_o), .replay_valid_o(replay_valid_o),
    .replay_chain_o(replay_chain_o), .replay_index_o(replay_index_o),
    .replay_data_o(replay_data_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] mdl [NCH][NEN];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] a_cmd(int c);  return 3'(1 + 2*c); endfunction
  function automatic logic [2:0] a_data(int c); return 3'(2 + 2*c); endfunction
  function automatic logic [31:0] cmd_word(int e, bit wr, bit go);
    return 32'(e & 7) | (32'(wr) << 4) | (32'(go) << 8);
  endfunction
  function automatic logic [31:0] ctrl_word(bit en, bit frc, logic [5:0] m, logic [2:0] ch);
    return 32'(en) | (32'(frc) << 1) | (32'(m) << 8) | (32'(ch) << 16);
  endfunction
  function automatic logic [DW-1:0] exp_read(int c, int e);
    return (e < NEN) ? mdl[c][e] : '0;
  endfunction

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic access(int c, int e, bit wr, logic [DW-1:0] d, bit chk_lat,
                        output logic [31:0] rdv);
    logic b1, b2, b3;
    if (wr) reg_wr(a_data(c), 32'(d));
    reg_wr(a_cmd(c), cmd_word(e, wr, 1'b0));
    reg_wr(a_cmd(c), cmd_word(e, wr, 1'b1));
    b1 = acc_busy_o[c];
    @(negedge clk); b2 = acc_busy_o[c];
    @(negedge clk); b3 = acc_busy_o[c];
    if (chk_lat) begin
      chk((e < NEN) ? "R5" : "R6", "busy after accept", 32'(b1), 32'd1);
      chk((e < NEN) ? "R5" : "R6", "busy second clock", 32'(b2), 32'd1);
      chk((e < NEN) ? "R5" : "R6", "busy cleared", 32'(b3), 32'd0);
    end
    if (wr && e < NEN) mdl[c][e] = d;
    rdv = '0;
    if (!wr) reg_rd(a_data(c), rdv);
  endtask

  task automatic read_chk(string req, int c, int e);
    logic [31:0] v;
    access(c, e, 1'b0, '0, 1'b0, v);
    chk(req, $sformatf("read c%0d e%0d", c, e), v, 32'(exp_read(c, e)));
  endtask

  // poke: 0 none, 1 ctrl write without force, 2 go write to chain 0 entry 0
  task automatic replay_chk(logic [5:0] m, logic [2:0] ch, int poke);
    int exp_c [NCH*NEN];
    int exp_e [NCH*NEN];
    int n_exp = 0;
    int k = 0;
    int end_cnt = -1;
    bit acc_seen = 0;
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEN; e++)
        if (ch[c] && m[e]) begin exp_c[n_exp] = c; exp_e[n_exp] = e; n_exp++; end
    reg_wr(3'd0, ctrl_word(1'b1, 1'b1, m, ch));
    chk("R9", "force set", 32'(restore_busy_o), 32'd1);
    for (int cnt = 1; cnt < 60; cnt++) begin
      @(negedge clk);
      if (reg_we) reg_we = 1'b0;
      if (acc_busy_o != 0) acc_seen = 1;
      if (replay_valid_o) begin
        if (k < n_exp) begin
          chk("R8", "replay cycle", 32'(cnt), 32'(3 + k));
          chk("R8", "replay chain", 32'(replay_chain_o), 32'(exp_c[k]));
          chk("R8", "replay index", 32'(replay_index_o), 32'(exp_e[k]));
          chk("R8", "replay data", 32'(replay_data_o), 32'(mdl[exp_c[k]][exp_e[k]]));
        end
        k++;
      end
      if (!restore_busy_o) begin end_cnt = cnt; break; end
      if (cnt == 1 && poke == 1) begin
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = ctrl_word(1'b1, 1'b0, m, ch);
      end
      if (cnt == 1 && poke == 2) begin
        reg_we = 1'b1; reg_addr = a_cmd(0); reg_wdata = cmd_word(0, 1'b1, 1'b1);
      end
    end
    chk("R8", "replay word count", 32'(k), 32'(n_exp));
    chk("R9", "force clear clock", 32'(end_cnt), 32'((n_exp == 0) ? 1 : 2 + n_exp));
    if (poke == 2) chk("R10", "no access during replay", 32'(acc_seen), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEN; e++) mdl[c][e] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "acc busy", 32'(acc_busy_o), 32'd0);
    chk("R1", "restore busy", 32'(restore_busy_o), 32'd0);
    chk("R1", "replay valid", 32'(replay_valid_o), 32'd0);
    for (int a = 0; a < 7; a++) begin
      reg_rd(3'(a), v);
      chk("R1", $sformatf("reg %0d", a), v, 32'd0);
    end

    // R7 disabled: go and force dropped
    reg_wr(a_data(1), 32'h0ABCDEF);
    reg_wr(a_cmd(1), cmd_word(2, 1'b1, 1'b1));
    chk("R7", "busy while disabled", 32'(acc_busy_o), 32'd0);
    @(negedge clk);
    chk("R7", "busy while disabled later", 32'(acc_busy_o), 32'd0);
    reg_wr(3'd0, ctrl_word(1'b0, 1'b1, 6'h3F, 3'h7));
    chk("R7", "force while disabled", 32'(restore_busy_o), 32'd0);
    repeat (4) @(negedge clk);
    chk("R7", "no replay while disabled", 32'(replay_valid_o), 32'd0);

    // R2 control readback
    reg_wr(3'd0, ctrl_word(1'b1, 1'b0, 6'h30, 3'h5));
    reg_rd(3'd0, v);
    chk("R2", "ctrl readback", v, ctrl_word(1'b1, 1'b0, 6'h30, 3'h5));
    read_chk("R7", 1, 2);   // dropped write left zero
    read_chk("R1", 2, 5);

    // R3, R4, R5, R11 directed
    access(0, 2, 1'b1, 28'h1111111, 1'b1, v);
    access(1, 2, 1'b1, 28'h2222222, 1'b1, v);
    access(0, 2, 1'b0, '0, 1'b1, v);
    chk("R11", "chain0 entry2", v, 32'h1111111);
    read_chk("R11", 1, 2);
    read_chk("R3", 2, 2);
    reg_rd(a_cmd(1), v);
    chk("R3", "cmd fields", v, cmd_word(2, 1'b0, 1'b0));

    // R6 out of range entries
    access(1, 7, 1'b1, 28'h5A5A5A5, 1'b1, v);
    access(1, 6, 1'b0, '0, 1'b1, v);
    chk("R6", "out of range read", v, 32'd0);
    read_chk("R6", 1, 2);

    // R10 data write into busy window is dropped
    reg_wr(a_cmd(0), cmd_word(2, 1'b0, 1'b1));
    reg_wr(a_data(0), 32'h0DEAD00);
    repeat (2) @(negedge clk);
    reg_rd(a_data(0), v);
    chk("R10", "data write while busy", v, 32'h1111111);

    // random traffic (R3 R4 R6)
    for (int i = 0; i < 80; i++) begin
      int c, e;
      bit wr;
      logic [DW-1:0] d;
      c  = int'($urandom % NCH);
      e  = (($urandom % 10) == 0) ? 6 + int'($urandom % 2) : int'($urandom % NEN);
      wr = 1'($urandom % 2);
      d  = DW'($urandom);
      access(c, e, wr, d, (i < 6), v);
      if (!wr) chk((e < NEN) ? "R4" : "R6", $sformatf("rand read c%0d e%0d", c, e), v, 32'(exp_read(c, e)));
    end
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEN; e++) access(c, e, 1'b1, DW'($urandom), 1'b0, v);

    // R8 R9 replays
    replay_chk(6'h10, 3'b011, 0);
    replay_chk(6'h30, 3'b111, 0);
    replay_chk(6'h00, 3'b111, 0);
    replay_chk(6'h3F, 3'b000, 0);
    replay_chk(6'h3F, 3'b111, 1);
    reg_rd(3'd0, v);
    chk("R9", "force cleared after replay", v & 32'h2, 32'd0);
    reg_wr(a_data(0), 32'h0F0F0F0);
    replay_chk(6'h21, 3'b101, 2);
    read_chk("R10", 0, 0);
    for (int i = 0; i < 4; i++) replay_chk(6'($urandom), 3'($urandom), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule